// File: doc/BRIEF.md
# Flash Byte Read/Write Address Sequencer

This block moves single bytes between a register bus and a serial NOR flash. It uses one data line in each direction. Software loads a flash address one byte at a time into four address registers and picks a 3-byte or 4-byte address phase with a mode bit. It then writes a trigger code into the command register. A read trigger clocks out an opcode, the address and an optional dummy byte, and then captures one byte into the read-data register. A write trigger first sends a write-enable opcode in its own chip-select frame, then a page-program frame that carries the address and the byte held in the write-data register.

The command register keeps the trigger value while the transfer runs and drops to zero when it ends, so software polls it for completion. After every transfer the stored address moves forward by one. Repeated triggers therefore walk consecutive flash bytes without the address being reloaded. Nothing is accepted until a guard register holds the unlock key. The dual and quad read style bits are stored for software only. The serial clock is divided down from the system clock by the parameter `HALF_PERIOD`.

Top module: `flash_pio_sequencer`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high and `spi_sck` is low. Every register reads 0, including the command register at offset 0x00.
- R2: While the guard register at offset 0x28 does not hold 0x30, a trigger written to the command register starts no frame and reads back as 0.
- R3: Writing 0x81 to the command register starts a read frame. The frame carries opcode 0x03, then the address most significant byte first, then the returned byte, all shifted MSB first in SPI mode 0. The byte appears at offset 0x04. The command register reads 0x81 while the frame is busy and 0 once it has finished.
- R4: When bit 0 of the fast register at offset 0x20 is 1, a read uses the opcode held at offset 0x24. It also sends one 0x00 dummy byte (8 clocks) between the address and the data.
- R5: Writing 0x90 to the command register sends a one-byte frame 0x06, raises chip select, then sends a frame of 0x02, the address and the byte held at offset 0x08.
- R6: Address bytes 0, 1 and 2 sit at offsets 0x10, 0x14 and 0x18, and byte 3 sits at offset 0x3C. Bit 4 of the mode register at offset 0x1C selects 4 address bytes when 1 and 3 when 0.
- R7: After each transfer the address reads back incremented by one. In 3-byte mode the low 24 bits wrap and byte 3 is untouched. In 4-byte mode the carry runs into byte 3.
- R8: The mode register keeps all 8 bits as written. The style bits 3:0 (0x1 dual data, 0x2 dual address, 0x4 quad data, 0x8 quad address) leave the single-line frame unchanged.
- R9: Trigger values other than 0x81 and 0x90 are ignored. While a transfer is busy, writes to the command, address and write-data registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a register write that arrives while a transfer is in flight. The bench loads a read trigger and, on the very next bus cycles, writes a new address byte, new write data and a write trigger. It then confirms that only the read frame appeared and that the address advanced from its old value. Carry propagation is reached by loading addresses ending in 0xFE, by loading 0xFFFFFF with a marked top byte in 3-byte mode, and by loading 0x00FFFFFF in 4-byte mode. A bench flash model checks every frame byte against addresses it computes itself.

// File: rtl/fps_pkg.sv
package fps_pkg;
   // register byte offsets (byte 3 of the address deliberately apart)
   localparam logic [7:0] OFS_CMD   = 8'h00;
   localparam logic [7:0] OFS_RDATA = 8'h04;
   localparam logic [7:0] OFS_WDATA = 8'h08;
   localparam logic [7:0] OFS_ADR0  = 8'h10;
   localparam logic [7:0] OFS_ADR1  = 8'h14;
   localparam logic [7:0] OFS_ADR2  = 8'h18;
   localparam logic [7:0] OFS_MODE  = 8'h1C;
   localparam logic [7:0] OFS_FAST  = 8'h20;
   localparam logic [7:0] OFS_RDOP  = 8'h24;
   localparam logic [7:0] OFS_GUARD = 8'h28;
   localparam logic [7:0] OFS_ADR3  = 8'h3C;

   localparam logic [7:0] TRIG_RD   = 8'h81;
   localparam logic [7:0] TRIG_WR   = 8'h90;
   localparam logic [7:0] GUARD_KEY = 8'h30;

   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_PROG   = 8'h02;
   localparam logic [7:0] OP_WREN   = 8'h06;

   localparam int MODE_FOURB_BIT = 4;
   localparam int ADDR_BYTES_MAX = 4;

   typedef enum logic [2:0] {
      PH_IDLE, PH_WREN, PH_GAP, PH_OP, PH_ADDR, PH_DUMMY, PH_DATA
   } phase_t;

   function automatic logic [7:0] adr_ofs(input int idx);
      case (idx)
         0:       return OFS_ADR0;
         1:       return OFS_ADR1;
         2:       return OFS_ADR2;
         default: return OFS_ADR3;
      endcase
   endfunction
endpackage

// File: rtl/fps_shift.sv
module fps_shift #(
   parameter int HALF_PERIOD = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx
);
   logic       active;
   logic       sck_q;
   logic [2:0] bitn;
   logic [7:0] sh;
   logic [7:0] rx_q;
   logic       done_q;
   logic       tick;

   generate
      if (HALF_PERIOD == 1) begin : g_nodiv
         assign tick = active;
      end else begin : g_div
         localparam int CW = $clog2(HALF_PERIOD);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (go || !active || tick) cnt <= '0;
            else                         cnt <= cnt + 1'b1;
         end
         assign tick = active && (cnt == CW'(HALF_PERIOD - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sck_q  <= 1'b0;
         bitn   <= '0;
         sh     <= '0;
         rx_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            active <= 1'b1;
            sh     <= tx;
            bitn   <= '0;
            sck_q  <= 1'b0;
         end else if (tick) begin
            if (!sck_q) begin
               sck_q <= 1'b1;
               rx_q  <= {rx_q[6:0], miso};
            end else begin
               sck_q <= 1'b0;
               if (bitn == 3'd7) begin
                  active <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bitn <= bitn + 3'd1;
                  sh   <= {sh[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign sck  = sck_q;
   assign mosi = sh[7];
   assign done = done_q;
   assign rx   = rx_q;

   p_done_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !sck_q);
endmodule

// File: rtl/fps_regs.sv
module fps_regs
   import fps_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_we,
   input  logic [7:0]  bus_addr,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata,
   input  logic        adv,
   input  logic        rd_done,
   input  logic [7:0]  rd_byte,
   output logic        launch_rd,
   output logic        launch_wr,
   output logic        busy,
   output logic        guard_ok,
   output logic [31:0] addr,
   output logic        four_byte,
   output logic        fast,
   output logic [7:0]  rd_opcode,
   output logic [7:0]  wr_byte
);
   localparam int AB = ADDR_BYTES_MAX;

   logic [7:0]      cmd_q;
   logic [7:0]      rdata_q;
   logic [7:0]      wdata_q;
   logic [7:0]      mode_q;
   logic            fast_q;
   logic [7:0]      rdop_q;
   logic [7:0]      guard_q;
   logic [8*AB-1:0] adr_q;
   logic [8*AB-1:0] adr_nxt;
   logic            cfg_we;
   logic            cmd_we;

   assign busy     = (cmd_q != 8'h00);
   assign guard_ok = (guard_q == GUARD_KEY);
   assign cfg_we   = bus_we && !busy;
   assign cmd_we   = cfg_we && guard_ok && (bus_addr == OFS_CMD);
   assign launch_rd = cmd_we && (bus_wdata == TRIG_RD);
   assign launch_wr = cmd_we && (bus_wdata == TRIG_WR);

   assign four_byte = mode_q[MODE_FOURB_BIT];
   assign adr_nxt   = four_byte ? adr_q + 32'd1
                                : {adr_q[31:24], adr_q[23:0] + 24'd1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         rdata_q <= '0;
         wdata_q <= '0;
         mode_q  <= '0;
         fast_q  <= 1'b0;
         rdop_q  <= '0;
         guard_q <= '0;
         adr_q   <= '0;
      end else begin
         if (adv)                            cmd_q <= '0;
         else if (launch_rd || launch_wr)    cmd_q <= bus_wdata;
         if (rd_done) rdata_q <= rd_byte;
         if (adv) begin
            adr_q <= adr_nxt;
         end else if (cfg_we) begin
            for (int i = 0; i < AB; i++)
               if (bus_addr == adr_ofs(i)) adr_q[8*i +: 8] <= bus_wdata;
         end
         if (cfg_we) begin
            case (bus_addr)
               OFS_WDATA: wdata_q <= bus_wdata;
               OFS_MODE:  mode_q  <= bus_wdata;
               OFS_FAST:  fast_q  <= bus_wdata[0];
               OFS_RDOP:  rdop_q  <= bus_wdata;
               OFS_GUARD: guard_q <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (bus_addr)
         OFS_CMD:   bus_rdata = cmd_q;
         OFS_RDATA: bus_rdata = rdata_q;
         OFS_WDATA: bus_rdata = wdata_q;
         OFS_ADR0:  bus_rdata = adr_q[7:0];
         OFS_ADR1:  bus_rdata = adr_q[15:8];
         OFS_ADR2:  bus_rdata = adr_q[23:16];
         OFS_ADR3:  bus_rdata = adr_q[31:24];
         OFS_MODE:  bus_rdata = mode_q;
         OFS_FAST:  bus_rdata = {7'd0, fast_q};
         OFS_RDOP:  bus_rdata = rdop_q;
         OFS_GUARD: bus_rdata = guard_q;
         default:   bus_rdata = 8'h00;
      endcase
   end

   assign addr      = adr_q;
   assign fast      = fast_q;
   assign rd_opcode = rdop_q;
   assign wr_byte   = wdata_q;

   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !adv) |=> $stable(adr_q));
   p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (adr_q[23:0] == $past(adr_q[23:0]) + 24'd1));
endmodule

// File: rtl/fps_seq.sv
module fps_seq
   import fps_pkg::*;
#(
   parameter int GAP_CYCLES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        launch_rd,
   input  logic        launch_wr,
   input  logic [31:0] addr,
   input  logic        four_byte,
   input  logic        fast,
   input  logic [7:0]  rd_opcode,
   input  logic [7:0]  wr_byte,
   input  logic        sh_done,
   input  logic [7:0]  sh_rx,
   output logic        sh_go,
   output logic [7:0]  sh_tx,
   output logic        cs_n,
   output logic        adv,
   output logic        rd_done,
   output logic [7:0]  rd_byte
);
   localparam int GW = $clog2(GAP_CYCLES + 1);

   phase_t        ph;
   logic          is_wr;
   logic [1:0]    aidx;
   logic [GW-1:0] gcnt;

   always_comb begin
      case (ph)
         PH_WREN: sh_tx = OP_WREN;
         PH_OP:   sh_tx = is_wr ? OP_PROG : (fast ? rd_opcode : OP_READ);
         PH_ADDR: sh_tx = addr[{aidx, 3'b000} +: 8];
         PH_DATA: sh_tx = is_wr ? wr_byte : 8'h00;
         default: sh_tx = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         is_wr   <= 1'b0;
         aidx    <= '0;
         gcnt    <= '0;
         cs_n    <= 1'b1;
         sh_go   <= 1'b0;
         adv     <= 1'b0;
         rd_done <= 1'b0;
         rd_byte <= '0;
      end else begin
         sh_go   <= 1'b0;
         adv     <= 1'b0;
         rd_done <= 1'b0;
         case (ph)
            PH_IDLE: begin
               if (launch_wr) begin
                  is_wr <= 1'b1;
                  ph    <= PH_WREN;
                  cs_n  <= 1'b0;
                  sh_go <= 1'b1;
               end else if (launch_rd) begin
                  is_wr <= 1'b0;
                  ph    <= PH_OP;
                  cs_n  <= 1'b0;
                  sh_go <= 1'b1;
               end
            end
            PH_WREN: if (sh_done) begin
               ph   <= PH_GAP;
               cs_n <= 1'b1;
               gcnt <= '0;
            end
            PH_GAP: begin
               if (gcnt == GW'(GAP_CYCLES - 1)) begin
                  ph    <= PH_OP;
                  cs_n  <= 1'b0;
                  sh_go <= 1'b1;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            PH_OP: if (sh_done) begin
               ph    <= PH_ADDR;
               aidx  <= four_byte ? 2'd3 : 2'd2;
               sh_go <= 1'b1;
            end
            PH_ADDR: if (sh_done) begin
               sh_go <= 1'b1;
               if (aidx == 2'd0) ph <= (!is_wr && fast) ? PH_DUMMY : PH_DATA;
               else              aidx <= aidx - 2'd1;
            end
            PH_DUMMY: if (sh_done) begin
               ph    <= PH_DATA;
               sh_go <= 1'b1;
            end
            PH_DATA: if (sh_done) begin
               ph   <= PH_IDLE;
               cs_n <= 1'b1;
               adv  <= 1'b1;
               if (!is_wr) begin
                  rd_done <= 1'b1;
                  rd_byte <= sh_rx;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   p_gap_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_GAP) |-> (cs_n && !sh_go));
   p_done_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sh_done |-> (ph != PH_IDLE && ph != PH_GAP));
endmodule

// File: rtl/flash_pio_sequencer.sv
module flash_pio_sequencer
   import fps_pkg::*;
#(
   parameter int HALF_PERIOD = 2,
   parameter int GAP_CYCLES  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_we,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       spi_sck,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   generate
      if (HALF_PERIOD < 1) begin : g_bad_half
         $error("HALF_PERIOD must be at least 1");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("GAP_CYCLES must be at least 1");
      end
   endgenerate

   logic        launch_rd, launch_wr, busy, guard_ok;
   logic [31:0] addr;
   logic        four_byte, fast;
   logic [7:0]  rd_opcode, wr_byte;
   logic        sh_go, sh_done;
   logic [7:0]  sh_tx, sh_rx;
   logic        adv, rd_done;
   logic [7:0]  rd_byte;

   fps_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .adv       (adv),
      .rd_done   (rd_done),
      .rd_byte   (rd_byte),
      .launch_rd (launch_rd),
      .launch_wr (launch_wr),
      .busy      (busy),
      .guard_ok  (guard_ok),
      .addr      (addr),
      .four_byte (four_byte),
      .fast      (fast),
      .rd_opcode (rd_opcode),
      .wr_byte   (wr_byte)
   );

   fps_seq #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_rd (launch_rd),
      .launch_wr (launch_wr),
      .addr      (addr),
      .four_byte (four_byte),
      .fast      (fast),
      .rd_opcode (rd_opcode),
      .wr_byte   (wr_byte),
      .sh_done   (sh_done),
      .sh_rx     (sh_rx),
      .sh_go     (sh_go),
      .sh_tx     (sh_tx),
      .cs_n      (spi_cs_n),
      .adv       (adv),
      .rd_done   (rd_done),
      .rd_byte   (rd_byte)
   );

   fps_shift #(.HALF_PERIOD(HALF_PERIOD)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (sh_go),
      .tx    (sh_tx),
      .miso  (spi_miso),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .done  (sh_done),
      .rx    (sh_rx)
   );

   p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   p_locked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!guard_ok && !busy) |-> spi_cs_n);
endmodule

// File: tb/tb_flash_pio_sequencer.sv
module tb_flash_pio_sequencer;
   import fps_pkg::*;

   localparam logic [7:0] FAST_OP = 8'h0B;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   wire  [7:0] bus_rdata;
   wire        sck, cs_n, mosi;
   logic       miso;

   always #5 clk = ~clk;

   flash_pio_sequencer dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(sck),
      .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso));

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   // flash model
   logic [7:0] mem [256];
   logic [7:0] frames [64][8];
   int         fcnt [64];
   int         nfr = 0;
   int         bitpos = 0;
   logic [7:0] shv = 8'h00;
   logic       cs_d = 1'b1;
   logic       sck_d = 1'b0;
   bit         model_four = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
         for (int i = 0; i < 64; i++) fcnt[i] = 0;
      end else if (!cs_n && cs_d) begin
         nfr = nfr + 1;
         fcnt[nfr % 64] = 0;
         bitpos = 0;
      end else if (!cs_n && sck && !sck_d) begin
         int cur;
         int nab;
         cur = nfr % 64;
         nab = model_four ? 4 : 3;
         shv = {shv[6:0], mosi};
         bitpos = bitpos + 1;
         if (bitpos == 8) begin
            bitpos = 0;
            if (fcnt[cur] < 8) frames[cur][fcnt[cur]] = shv;
            fcnt[cur] = fcnt[cur] + 1;
            if (frames[cur][0] == OP_PROG && fcnt[cur] == 2 + nab)
               mem[frames[cur][nab]] = shv;
         end
      end
      cs_d = cs_n;
      sck_d = sck;
   end

   always_comb begin
      int cur;
      int nab;
      int hdr;
      cur = nfr % 64;
      nab = model_four ? 4 : 3;
      hdr = 1 + nab + ((frames[cur][0] == FAST_OP) ? 1 : 0);
      miso = 1'b0;
      if (!cs_n && fcnt[cur] >= hdr &&
          (frames[cur][0] == OP_READ || frames[cur][0] == FAST_OP))
         miso = mem[frames[cur][nab]][7 - bitpos];
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] c;
      int n = 0;
      do begin rd(OFS_CMD, c); n++; end while (c != 8'h00 && n < 5000);
   endtask

   task automatic set_addr(input logic [31:0] a);
      wr(OFS_ADR0, a[7:0]);  wr(OFS_ADR1, a[15:8]);
      wr(OFS_ADR2, a[23:16]); wr(OFS_ADR3, a[31:24]);
   endtask

   task automatic get_addr(output logic [31:0] a);
      logic [7:0] b0, b1, b2, b3;
      rd(OFS_ADR0, b0); rd(OFS_ADR1, b1); rd(OFS_ADR2, b2); rd(OFS_ADR3, b3);
      a = {b3, b2, b1, b0};
   endtask

   function automatic logic [31:0] step(input logic [31:0] a, input int k, input bit four);
      if (four) return a + 32'(k);
      return {a[31:24], a[23:0] + 24'(k)};
   endfunction

   task automatic check_addr_bytes(input string req, input int f, input logic [31:0] a, input int nab);
      for (int j = 0; j < nab; j++)
         check(req, frames[f][1+j], a[8*(nab-1-j) +: 8]);
   endtask

   task automatic check_read(input int f0, input logic [31:0] a, input bit four, input bit fst);
      int f, nab;
      f = (f0 + 1) % 64;
      nab = four ? 4 : 3;
      check("R3 one read frame", 32'(nfr), 32'(f0 + 1));
      check(fst ? "R4 fast opcode" : "R3 read opcode", frames[f][0], fst ? FAST_OP : OP_READ);
      check_addr_bytes(four ? "R6 4-byte address" : "R6 3-byte address", f, a, nab);
      if (fst) check("R4 dummy byte", frames[f][1+nab], 8'h00);
      check("R4 read frame length", 32'(fcnt[f]), 32'(nab + 2 + (fst ? 1 : 0)));
   endtask

   task automatic check_write(input int f0, input logic [31:0] a, input bit four, input logic [7:0] d);
      int fa, fb, nab;
      fa = (f0 + 1) % 64;
      fb = (f0 + 2) % 64;
      nab = four ? 4 : 3;
      check("R5 two write frames", 32'(nfr), 32'(f0 + 2));
      check("R5 enable frame length", 32'(fcnt[fa]), 32'd1);
      check("R5 enable opcode", frames[fa][0], OP_WREN);
      check("R5 program opcode", frames[fb][0], OP_PROG);
      check_addr_bytes("R5 program address", fb, a, nab);
      check("R5 program data", frames[fb][1+nab], d);
      check("R5 program frame length", 32'(fcnt[fb]), 32'(nab + 2));
   endtask

   initial begin
      logic [7:0]  v;
      logic [31:0] a;
      int          f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(OFS_CMD, v);   check("R1 cmd", v, 8'h00);
      rd(OFS_MODE, v);  check("R1 mode", v, 8'h00);
      rd(OFS_RDATA, v); check("R1 rdata", v, 8'h00);
      get_addr(a);      check("R1 address", a, 32'h0);
      check("R1 cs_n high", cs_n, 1'b1);
      check("R1 sck low", sck, 1'b0);

      // R2 locked before the key
      wr(OFS_ADR0, 8'h11);
      f0 = nfr;
      wr(OFS_CMD, TRIG_RD);
      rd(OFS_CMD, v); check("R2 locked cmd reads 0", v, 8'h00);
      repeat (80) @(negedge clk);
      check("R2 no frame while locked", 32'(nfr), 32'(f0));
      wr(OFS_GUARD, GUARD_KEY);

      // R8 mode register keeps all bits
      wr(OFS_MODE, 8'hFF); rd(OFS_MODE, v); check("R8 mode all bits", v, 8'hFF);
      wr(OFS_MODE, 8'h0F); rd(OFS_MODE, v); check("R8 mode style bits", v, 8'h0F);
      wr(OFS_RDOP, FAST_OP);

      // sweep address width, fast read and style bits
      for (int s = 0; s < 4; s++) begin
         bit four, fst;
         logic [31:0] base;
         logic [7:0]  dv [3];
         four = s[1];
         fst  = s[0];
         model_four = four;
         wr(OFS_MODE, {3'b000, four, 4'(1 << s)});
         wr(OFS_FAST, {7'd0, fst});
         base = {8'h40 + 8'(s), 8'h12, 8'h34 + 8'(s), 8'hFE};
         set_addr(base);
         for (int k = 0; k < 3; k++) begin
            dv[k] = (8'hFE + 8'(k)) ^ (8'h3C + 8'(s));
            wr(OFS_WDATA, dv[k]);
            f0 = nfr;
            wr(OFS_CMD, TRIG_WR);
            wait_idle();
            check_write(f0, step(base, k, four), four, dv[k]);
         end
         get_addr(a); check("R7 address after writes", a, step(base, 3, four));
         set_addr(base);
         for (int k = 0; k < 3; k++) begin
            f0 = nfr;
            wr(OFS_CMD, TRIG_RD);
            wait_idle();
            check_read(f0, step(base, k, four), four, fst);
            rd(OFS_RDATA, v); check("R3 read data", v, dv[k]);
         end
         get_addr(a); check("R7 address after reads", a, step(base, 3, four));
      end

      // R7 wrap in 3-byte mode, carry in 4-byte mode
      wr(OFS_FAST, 8'h00);
      model_four = 0; wr(OFS_MODE, 8'h00);
      set_addr(32'h5AFF_FFFF);
      f0 = nfr; wr(OFS_CMD, TRIG_RD); wait_idle();
      check_read(f0, 32'h5AFF_FFFF, 1'b0, 1'b0);
      get_addr(a); check("R7 24-bit wrap keeps byte 3", a, 32'h5A00_0000);
      model_four = 1; wr(OFS_MODE, 8'h10);
      set_addr(32'h00FF_FFFF);
      f0 = nfr; wr(OFS_CMD, TRIG_RD); wait_idle();
      check_read(f0, 32'h00FF_FFFF, 1'b1, 1'b0);
      get_addr(a); check("R7 carry into byte 3", a, 32'h0100_0000);

      // R9 unknown trigger ignored
      f0 = nfr;
      wr(OFS_CMD, 8'h55);
      rd(OFS_CMD, v); check("R9 unknown trigger reads 0", v, 8'h00);
      repeat (80) @(negedge clk);
      check("R9 unknown trigger no frame", 32'(nfr), 32'(f0));

      // R9 writes during a busy transfer are ignored
      set_addr(32'h0000_0020);
      wr(OFS_WDATA, 8'h99);
      f0 = nfr;
      wr(OFS_CMD, TRIG_RD);
      rd(OFS_CMD, v); check("R3 cmd holds trigger while busy", v, TRIG_RD);
      wr(OFS_ADR0, 8'h77);
      wr(OFS_WDATA, 8'h66);
      wr(OFS_CMD, TRIG_WR);
      wait_idle();
      check_read(f0, 32'h0000_0020, 1'b1, 1'b0);
      rd(OFS_ADR0, v);  check("R9 address write ignored while busy", v, 8'h21);
      rd(OFS_WDATA, v); check("R9 wdata write ignored while busy", v, 8'h99);
      rd(OFS_RDATA, v); check("R3 read data of fresh byte", v, 8'h20 ^ 8'hA5);
      check("R1 idle sck low", sck, 1'b0);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule